// File: doc/BRIEF.md
# SPI Master Frame Sequencer

This block is the serial engine of an SPI master that idles with the serial clock low. It takes transmit words over a valid/ready handshake and shifts each one out most significant bit first. At the same time it shifts in the receive line and presents each completed word together with a one-cycle strobe. Word length runs from 4 to 16 bits. A clock-phase input picks one of two modes. In phase 0 data changes on the falling edge and is sampled on the rising edge. In phase 1 data changes on the rising edge and is sampled on the falling edge.

The sequencer builds each frame out of serial half-periods. Each half-period lasts a programmable number of system clocks. Frame select falls first, and the transmit pad is enabled at the same moment. The clock edges follow after the setup delay required by the selected phase. Frame select rises one full serial period after the final capture edge. Between back-to-back words, phase 0 always returns frame select high for one serial period. Phase 1 keeps frame select low and starts the next word's first rising edge in the half-period right after the final capture.

Top module: `spi_frame_master`

## Requirements
- R1: While no frame is active, sclk is 0, fs_n is 1, mosi is 0, mosi_oe is 0 and tx_ready equals enable.
- R2: sclk_oe is 1 when slave_mode is 0 and 0 when slave_mode is 1.
- R3: A frame starts only on a cycle with tx_valid and tx_ready both high, and fs_n falls in the following cycle. mosi_oe is high exactly while fs_n is low, and mosi stays 0 during the first half-period of a frame.
- R4: A serial half-period lasts half_div system clocks, and a value of 0 is treated as 1. The value is taken whenever a word is accepted.
- R5: With cpha=0, the MSB is driven from half-period 1 and sclk is high in the even half-periods 2..2N. Each rising edge samples, and the next bit appears at the following falling edge.
- R6: With cpha=1, sclk is high in the odd half-periods 1..2N-1, so the first rising edge comes together with the MSB. The data changes on rising edges and is sampled on falling edges.
- R7: Words go out MSB first using the low N bits of tx_data. N is word_len clamped to the range 4..16, and it is taken when the word is accepted.
- R8: For a word of N bits whose final capture happens in half-period 2N, fs_n stays low through half-period 2N+1 and goes high after that.
- R9: After a frame ends, fs_n stays high for at least two half-periods. tx_ready is raised again only in the last cycle of that gap or later. A queued word therefore restarts with fs_n high for exactly one serial period.
- R10: With cpha=1 and a word ready, tx_ready is high in the last cycle of half-period 2N. The next word then continues with fs_n still low, and its MSB and first rising edge appear in the next cycle.
- R11: rx_valid is high for exactly one cycle, the first cycle of half-period 2N. In that cycle rx_data holds the N received bits right-aligned and zero-extended.
- R12: tx_ready is never high while enable is 0. Dropping enable lets the current word finish and stops any further words from being accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Allows new words to be accepted |
| slave_mode | input | 1 | Releases the serial clock pad when 1 |
| cpha | input | 1 | Clock phase select |
| half_div | input | 8 | System clocks per serial half-period (0 acts as 1) |
| word_len | input | 5 | Bits per word, clamped to 4..16 |
| tx_data | input | 16 | Transmit word, right-aligned |
| tx_valid | input | 1 | Transmit word available |
| tx_ready | output | 1 | Sequencer takes the word this cycle |
| miso | input | 1 | Serial receive line |
| sclk | output | 1 | Serial clock |
| sclk_oe | output | 1 | Serial clock pad enable |
| fs_n | output | 1 | Active-low frame select |
| mosi | output | 1 | Serial transmit line |
| mosi_oe | output | 1 | Transmit pad enable |
| rx_data | output | 16 | Received word, right-aligned |
| rx_valid | output | 1 | One-cycle strobe for rx_data |

## Verification
In phase 1 with a half-period of one system clock, half-period 2N is a single cycle. The strobe for the word just received therefore lands in the same cycle as the handshake that takes the next word. A phase-1 stream of queued words run with half_div at 0 and 1 provokes this overlap. The bench model then judges, in that one cycle, both the strobe and rx_data against the slave word and tx_ready against its own acceptance point. In the cycle that follows it also checks that the next word's MSB and its rising edge have appeared.

// File: rtl/spi_fm_pkg.sv
package spi_fm_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LEAD,
      ST_SHIFT,
      ST_TAIL,
      ST_GAP
   } seq_state_e;

endpackage

// File: rtl/spi_fm_half_timer.sv
module spi_fm_half_timer #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             load,
   input  logic [DIV_W-1:0] div_in,
   output logic             tick
);

   logic [DIV_W-1:0] div_q;
   logic [DIV_W-1:0] cnt;

   assign tick = run && (cnt == div_q - DIV_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q <= DIV_W'(1);
         cnt   <= '0;
      end else begin
         if (load) begin
            div_q <= (div_in == '0) ? DIV_W'(1) : div_in;
         end
         if (load || !run || tick) begin
            cnt <= '0;
         end else begin
            cnt <= cnt + DIV_W'(1);
         end
      end
   end

endmodule

// File: rtl/spi_fm_shifter.sv
module spi_fm_shifter #(
   parameter int DATA_W = 16,
   parameter int LEN_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [LEN_W-1:0]  len_in,
   input  logic [DATA_W-1:0] tx_word,
   input  logic              shift_tx,
   input  logic              capture,
   input  logic              capture_last,
   input  logic              miso,
   output logic              mosi_bit,
   output logic [DATA_W-1:0] rx_word,
   output logic              rx_strobe
);

   logic [DATA_W-1:0] txsr;
   logic [DATA_W-1:0] rxsr;
   logic [LEN_W-1:0]  shamt;
   logic [DATA_W-1:0] rx_next;

   assign shamt    = LEN_W'(DATA_W) - len_in;
   assign mosi_bit = txsr[DATA_W-1];
   assign rx_next  = {rxsr[DATA_W-2:0], miso};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         txsr <= '0;
      end else if (load) begin
         txsr <= tx_word << shamt;
      end else if (shift_tx) begin
         txsr <= txsr << 1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rxsr      <= '0;
         rx_word   <= '0;
         rx_strobe <= 1'b0;
      end else begin
         rx_strobe <= capture_last;
         if (load) begin
            rxsr <= '0;
         end else if (capture) begin
            rxsr <= rx_next;
         end
         if (capture_last) begin
            rx_word <= rx_next;
         end
      end
   end

endmodule

// File: rtl/spi_fm_ctrl.sv
module spi_fm_ctrl
   import spi_fm_pkg::*;
#(
   parameter int LEN_W = 5,
   parameter int K_W   = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             cpha,
   input  logic             tx_valid,
   input  logic             tick,
   input  logic [LEN_W-1:0] len_eff,
   output logic             tx_ready,
   output logic             load,
   output logic             shift_tx,
   output logic             capture,
   output logic             capture_last,
   output logic             run,
   output logic             sclk,
   output logic             fs_n,
   output logic             drive_data
);

   seq_state_e       st;
   logic [K_W-1:0]   k;
   logic [LEN_W-1:0] len_q;
   logic             cpha_q;
   logic [K_W-1:0]   k_end;
   logic [K_W-1:0]   k_inc;
   logic             at_end;
   logic             in_shift;

   assign k_end    = {len_q, 1'b0};
   assign k_inc    = k + K_W'(1);
   assign in_shift = (st == ST_SHIFT);
   assign at_end   = in_shift && (k == k_end);

   assign tx_ready = enable &&
                     ((st == ST_IDLE) ||
                      (tick && (st == ST_GAP) && k[0]) ||
                      (tick && at_end && cpha_q));
   assign load         = tx_ready && tx_valid;
   assign shift_tx     = tick && in_shift && !at_end && !k[0];
   assign capture      = tick && in_shift && k[0];
   assign capture_last = capture && (k_inc == k_end);
   assign run          = (st != ST_IDLE);

   assign fs_n       = !((st == ST_LEAD) || in_shift || (st == ST_TAIL));
   assign sclk       = in_shift && (cpha_q ? k[0] : !k[0]);
   assign drive_data = in_shift || (st == ST_TAIL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         len_q  <= LEN_W'(4);
         cpha_q <= 1'b0;
      end else if (load) begin
         len_q  <= len_eff;
         cpha_q <= cpha;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= ST_IDLE;
         k  <= '0;
      end else begin
         unique case (st)
            ST_IDLE: begin
               k <= '0;
               if (load) st <= ST_LEAD;
            end
            ST_LEAD: begin
               if (tick) begin
                  st <= ST_SHIFT;
                  k  <= K_W'(1);
               end
            end
            ST_SHIFT: begin
               if (tick) begin
                  if (!at_end) begin
                     k <= k_inc;
                  end else if (load) begin
                     k <= K_W'(1);
                  end else begin
                     st <= ST_TAIL;
                  end
               end
            end
            ST_TAIL: begin
               if (tick) begin
                  st <= ST_GAP;
                  k  <= '0;
               end
            end
            ST_GAP: begin
               if (tick) begin
                  if (!k[0]) begin
                     k <= K_W'(1);
                  end else if (load) begin
                     st <= ST_LEAD;
                  end else begin
                     st <= ST_IDLE;
                  end
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/spi_frame_master.sv
module spi_frame_master #(
   parameter int DATA_W   = 16,
   parameter int MIN_BITS = 4,
   parameter int DIV_W    = 8,
   localparam int LEN_W   = $clog2(DATA_W + 1),
   localparam int K_W     = LEN_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              slave_mode,
   input  logic              cpha,
   input  logic [DIV_W-1:0]  half_div,
   input  logic [LEN_W-1:0]  word_len,
   input  logic [DATA_W-1:0] tx_data,
   input  logic              tx_valid,
   output logic              tx_ready,
   input  logic              miso,
   output logic              sclk,
   output logic              sclk_oe,
   output logic              fs_n,
   output logic              mosi,
   output logic              mosi_oe,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_valid
);

   if (DATA_W < 2) begin : g_bad_width
      $error("DATA_W must be at least 2");
   end
   if (MIN_BITS < 1 || MIN_BITS > DATA_W) begin : g_bad_min
      $error("MIN_BITS must lie in 1..DATA_W");
   end
   if (DIV_W < 1) begin : g_bad_div
      $error("DIV_W must be at least 1");
   end

   logic [LEN_W-1:0] len_eff;

   if (MIN_BITS == DATA_W) begin : g_fixed_len
      assign len_eff = LEN_W'(DATA_W);
   end else begin : g_clamp_len
      always_comb begin
         if (word_len < LEN_W'(MIN_BITS)) begin
            len_eff = LEN_W'(MIN_BITS);
         end else if (word_len > LEN_W'(DATA_W)) begin
            len_eff = LEN_W'(DATA_W);
         end else begin
            len_eff = word_len;
         end
      end
   end

   logic tick, load, shift_tx, capture, capture_last, run;
   logic drive_data, mosi_bit;

   spi_fm_half_timer #(.DIV_W(DIV_W)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (run),
      .load   (load),
      .div_in (half_div),
      .tick   (tick)
   );

   spi_fm_ctrl #(.LEN_W(LEN_W), .K_W(K_W)) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .enable       (enable),
      .cpha         (cpha),
      .tx_valid     (tx_valid),
      .tick         (tick),
      .len_eff      (len_eff),
      .tx_ready     (tx_ready),
      .load         (load),
      .shift_tx     (shift_tx),
      .capture      (capture),
      .capture_last (capture_last),
      .run          (run),
      .sclk         (sclk),
      .fs_n         (fs_n),
      .drive_data   (drive_data)
   );

   spi_fm_shifter #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_shift (
      .clk          (clk),
      .rst_n        (rst_n),
      .load         (load),
      .len_in       (len_eff),
      .tx_word      (tx_data),
      .shift_tx     (shift_tx),
      .capture      (capture),
      .capture_last (capture_last),
      .miso         (miso),
      .mosi_bit     (mosi_bit),
      .rx_word      (rx_data),
      .rx_strobe    (rx_valid)
   );

   assign mosi    = drive_data && mosi_bit;
   assign mosi_oe = !fs_n;
   assign sclk_oe = !slave_mode;

endmodule

// File: rtl/spi_fm_checker.sv
module spi_fm_checker (
   input logic clk,
   input logic rst_n,
   input logic enable,
   input logic tx_valid,
   input logic tx_ready,
   input logic fs_n,
   input logic sclk,
   input logic mosi,
   input logic rx_valid
);

   assert_idle_lines_R1: assert property (@(posedge clk) disable iff (!rst_n)
      fs_n |-> (!sclk && !mosi));

   assert_start_after_take_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(fs_n) |-> $past(tx_valid && tx_ready));

   assert_rise_inside_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sclk) |-> !fs_n);

   assert_quiet_clock_at_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fs_n) |-> (!sclk && $past(!sclk)));

   assert_single_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);

   assert_ready_needs_enable_R12: assert property (@(posedge clk) disable iff (!rst_n)
      tx_ready |-> enable);

endmodule

bind spi_frame_master spi_fm_checker u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .enable   (enable),
   .tx_valid (tx_valid),
   .tx_ready (tx_ready),
   .fs_n     (fs_n),
   .sclk     (sclk),
   .mosi     (mosi),
   .rx_valid (rx_valid)
);

// File: tb/spi_frame_master_test.sv
module spi_frame_master_test;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        enable = 1'b0;
   logic        slave_mode = 1'b0;
   logic        cpha = 1'b0;
   logic [7:0]  half_div = 8'd1;
   logic [4:0]  word_len = 5'd8;
   logic [15:0] tx_data = 16'h0;
   logic        tx_valid = 1'b0;
   logic        tx_ready;
   logic        miso;
   logic        sclk, sclk_oe, fs_n, mosi, mosi_oe;
   logic [15:0] rx_data;
   logic        rx_valid;

   always #(CLK_PERIOD/2) clk = ~clk;

   spi_frame_master uut (
      .clk(clk), .rst_n(rst_n), .enable(enable), .slave_mode(slave_mode),
      .cpha(cpha), .half_div(half_div), .word_len(word_len),
      .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
      .miso(miso), .sclk(sclk), .sclk_oe(sclk_oe), .fs_n(fs_n),
      .mosi(mosi), .mosi_oe(mosi_oe), .rx_data(rx_data), .rx_valid(rx_valid)
   );

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;

   // stimulus store
   logic [15:0] tx_words [0:63];
   logic [15:0] sl_words [0:63];
   int          n_words = 0;
   logic        src_on = 1'b0;

   // reference model state (mode 0 idle, 1 frame, 2 gap)
   int          m_mode = 0;
   int          m_h = 0;
   int          m_c = 0;
   int          m_g = 0;
   int          m_div = 1;
   int          m_len = 4;
   logic        m_cpha = 1'b0;
   logic [15:0] m_word = 16'h0;
   logic [15:0] m_slave = 16'h0;
   int          acc_idx = 0;

   task automatic chk(input bit ok, input string tag, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", tag, what, act, exp, cyc);
      end
   endtask

   function automatic int clamp_len(input int l);
      if (l < 4) return 4;
      if (l > 16) return 16;
      return l;
   endfunction

   function automatic bit m_last();
      return (m_c == m_div - 1);
   endfunction

   function automatic bit exp_ready();
      return enable && ((m_mode == 0) ||
                        (m_last() && m_mode == 2 && m_g == 1) ||
                        (m_last() && m_mode == 1 && m_cpha && m_h == 2*m_len));
   endfunction

   function automatic int bit_at();
      int b;
      b = (m_h == 0) ? 0 : (m_h - 1) / 2;
      if (b > m_len - 1) b = m_len - 1;
      return m_len - 1 - b;
   endfunction

   // bench slave: drives the current slave word, MSB first
   logic miso_r;
   always @(m_mode or m_h or m_len or m_slave) begin
      if (m_mode == 1) miso_r = m_slave[bit_at()];
      else             miso_r = 1'b0;
   end
   assign miso = miso_r;

   // reference model advance
   always @(posedge clk) begin
      bit take, lastc;
      if (!rst_n) begin
         m_mode <= 0; m_h <= 0; m_c <= 0; m_g <= 0; m_div <= 1;
      end else begin
         lastc = m_last();
         take  = exp_ready() && tx_valid;
         if (take) begin
            m_word  <= tx_data;
            m_len   <= clamp_len(int'(word_len));
            m_cpha  <= cpha;
            m_div   <= (half_div == 8'd0) ? 1 : int'(half_div);
            m_slave <= sl_words[acc_idx];
            acc_idx <= acc_idx + 1;
            m_c     <= 0;
         end
         case (m_mode)
            0: if (take) begin m_mode <= 1; m_h <= 0; end
            1: begin
               if (!lastc) m_c <= m_c + 1;
               else begin
                  m_c <= 0;
                  if (m_h == 2*m_len) m_h <= take ? 1 : m_h + 1;
                  else if (m_h == 2*m_len + 1) begin m_mode <= 2; m_g <= 0; end
                  else m_h <= m_h + 1;
               end
            end
            default: begin
               if (!lastc) m_c <= m_c + 1;
               else begin
                  m_c <= 0;
                  if (m_g == 0) m_g <= 1;
                  else if (take) begin m_mode <= 1; m_h <= 0; end
                  else m_mode <= 0;
               end
            end
         endcase
      end
   end

   // source driver
   always @(negedge clk) begin
      tx_valid = src_on && (acc_idx < n_words);
      tx_data  = (acc_idx < 64) ? tx_words[acc_idx] : 16'h0;
   end

   // per-cycle comparison
   always @(negedge clk) begin
      bit e_sclk, e_fs, e_mosi, e_rv, e_rdy;
      string t;
      if (rst_n) begin
         e_fs   = (m_mode != 1);
         e_sclk = (m_mode == 1) && m_h >= 1 && m_h <= 2*m_len &&
                  (m_cpha ? (m_h % 2 == 1) : (m_h % 2 == 0));
         e_mosi = (m_mode == 1) && m_h >= 1 && m_word[bit_at()];
         e_rv   = (m_mode == 1) && m_h == 2*m_len && m_c == 0;
         e_rdy  = exp_ready();
         if (m_mode == 0) t = "R1";
         else if (m_mode == 2) t = "R9";
         else t = m_cpha ? "R6" : "R5";
         chk(sclk == e_sclk, t, "sclk", sclk, e_sclk);
         chk(fs_n == e_fs, (m_mode == 2) ? "R9" : "R8", "fs_n", fs_n, e_fs);
         chk(mosi == e_mosi, (m_mode == 0) ? "R1" : "R7", "mosi", mosi, e_mosi);
         chk(mosi_oe == !e_fs, "R3", "mosi_oe", mosi_oe, !e_fs);
         chk(tx_ready == e_rdy, (m_mode == 1) ? "R10" : ((m_mode == 2) ? "R9" : "R12"),
             "tx_ready", tx_ready, e_rdy);
         chk(sclk_oe == !slave_mode, "R2", "sclk_oe", sclk_oe, !slave_mode);
         chk(rx_valid == e_rv, "R11", "rx_valid", rx_valid, e_rv);
         if (e_rv) begin
            chk(rx_data == (m_slave & 16'((32'h1 << m_len) - 1)), "R11", "rx_data",
                rx_data, m_slave & 16'((32'h1 << m_len) - 1));
         end
      end
   end

   // watchdog
   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   task automatic start_stream(input int n, input bit cp, input int len,
                               input int div, input int seed);
      @(negedge clk);
      cpha     = cp;
      word_len = 5'(len);
      half_div = 8'(div);
      for (int i = 0; i < n; i++) begin
         tx_words[n_words + i] = 16'((n_words + i) * 16'h3B5 + seed * 16'h1F03 + 16'hA5C3);
         sl_words[n_words + i] = 16'((n_words + i) * 16'h71D + seed * 16'h0E57 + 16'h5A3C);
      end
      n_words = n_words + n;
      src_on  = 1'b1;
   endtask

   task automatic wait_done();
      while (acc_idx < n_words || m_mode != 0) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   task automatic measure_high(input int exp, input string what);
      int n = 0;
      while (!sclk) @(negedge clk);
      while (sclk) begin n++; @(negedge clk); end
      chk(n == exp, "R4", what, n, exp);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      // R1: reset state
      chk(fs_n == 1'b1, "R1", "reset fs_n", fs_n, 1);
      chk(sclk == 1'b0, "R1", "reset sclk", sclk, 0);
      chk(mosi == 1'b0, "R1", "reset mosi", mosi, 0);
      chk(mosi_oe == 1'b0, "R1", "reset mosi_oe", mosi_oe, 0);
      chk(rx_valid == 1'b0, "R11", "reset rx_valid", rx_valid, 0);
      rst_n = 1'b1;

      // R12: word offered while disabled is not taken
      start_stream(2, 1'b0, 8, 2, 1);
      repeat (40) @(negedge clk);
      chk(acc_idx == 0, "R12", "words taken while disabled", acc_idx, 0);
      chk(fs_n == 1'b1, "R12", "fs_n while disabled", fs_n, 1);
      enable = 1'b1;
      wait_done();

      // R2: slave mode releases the clock pad
      slave_mode = 1'b1;
      repeat (2) @(negedge clk);
      chk(sclk_oe == 1'b0, "R2", "sclk_oe slave", sclk_oe, 0);
      slave_mode = 1'b0;
      repeat (2) @(negedge clk);

      // R9: phase 0 back-to-back with inter-word pulse
      start_stream(3, 1'b0, 4, 1, 2);
      wait_done();

      // R10: phase 1 continuous, 16-bit, strobe and handshake coincide
      start_stream(4, 1'b1, 16, 1, 3);
      wait_done();

      // R4: half period of three clocks, phase 1, 5 bits
      start_stream(1, 1'b1, 5, 3, 4);
      measure_high(3, "sclk high length div 3");
      wait_done();

      // R4/R7: div 0 acts as 1, length 2 clamps to 4
      start_stream(2, 1'b0, 2, 0, 5);
      measure_high(1, "sclk high length div 0");
      wait_done();

      // R7: length 20 clamps to 16
      start_stream(2, 1'b1, 20, 2, 6);
      wait_done();

      // R12: enable dropped mid-stream
      start_stream(4, 1'b0, 6, 1, 7);
      while (acc_idx < n_words - 2) @(negedge clk);
      enable = 1'b0;
      repeat (80) @(negedge clk);
      chk(acc_idx == n_words - 2, "R12", "words taken after disable", acc_idx, n_words - 2);
      chk(fs_n == 1'b1, "R12", "fs_n after disable", fs_n, 1);
      enable = 1'b1;
      wait_done();

      // R10: tight phase 1 stream with half_div 0
      start_stream(5, 1'b1, 4, 0, 8);
      wait_done();

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule